// File: doc/BRIEF.md
# Fixed-Point Add/Subtract Unit

This block is the integer add and subtract stage of a 64-bit execution pipe. Each issued operation names one of seventeen operation codes. It also supplies two register operands, a flag saying the first register field was zero, a 16-bit immediate, the next-instruction address and two control bits: OE for overflow recording and RC for a compare-with-zero result. One clock later the block returns the 64-bit result, the raw carry-out and signed overflow of the addition, and an optional three-bit sign/zero code.

Every operation reduces to one addition of three terms: a first operand (a register, its complement, zero, or the instruction address), a second operand (a register, an extended immediate, all ones, or zero), and a carry-in (0, 1, the stored carry bit or the stored overflow bit). Subtraction always takes the form "complement of the first register plus the second plus one", so it yields the second operand minus the first. The block holds two status bits: a carry bit and an overflow bit. The extended forms read these bits as the carry-in, and the carrying forms and the OE forms write them.

Top module: `fxu_addsub`

## Requirements
- R1: While rst_n is low and after it rises, out_valid, out_result, out_carry, out_ovf, out_cr, out_ov_wr, ca_q and ov_q are all zero until the first operation is issued.
- R2: An operation issued with in_valid high in cycle n shows out_valid high, together with all its results, in cycle n+1. Without in_valid, out_valid is low in the next cycle.
- R3: Operation codes 0 ADD (ra+rb), 1 SUBF (rb-ra), 7 ADDC (ra+rb), 8 SUBFC (rb-ra) and 16 NEG (0-ra) produce the stated result. Subtraction is formed as ~ra + operand + 1.
- R4: Code 2 ADDI adds the sign-extended immediate. Code 3 ADDIS adds the immediate shifted left 16 and then sign-extended. In these two codes only, in_ra_zero selects zero in place of in_ra.
- R5: Code 4 ADDPCIS returns in_nia plus the immediate shifted left 16 and sign-extended. in_ra and in_ra_zero play no part.
- R6: out_carry is bit 64 of the unsigned 65-bit sum. Codes 5 ADDIC, 6 SUBFIC (ext(imm)-ra), 7, 8, 9, 10, 11, 12, 13 and 14 copy it into ca_q. All other codes leave ca_q unchanged.
- R7: The extended codes take ca_q as carry-in: 9 ADDE ra+rb+ca, 10 SUBFE ~ra+rb+ca, 11 ADDME ra+all-ones+ca, 12 SUBFME ~ra+all-ones+ca, 13 ADDZE ra+ca, 14 SUBFZE ~ra+ca.
- R8: Code 15 ADDEX computes ra+rb+ov_q and writes its carry-out into ov_q. It leaves ca_q unchanged and never raises out_ov_wr, whatever in_oe is.
- R9: out_ovf is set when the two addends have the same sign and the result's sign differs. When in_oe is 1 with codes 0, 1, 7 to 14 or 16, out_ov_wr pulses and ov_q takes out_ovf. In_oe has no effect for codes 2 to 6.
- R10: With in_rc set, out_cr is {negative, positive, zero} (bit 2, bit 1, bit 0) for the signed result, exactly one bit set. With in_rc clear, out_cr is 000.
- R11: A carry chain split into carry-select blocks gives the same result and carry as a full-width add, including carries rippling across every block boundary.
- R12: Cycles without in_valid change neither ca_q nor ov_q.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Issue an operation this cycle |
| in_op | input | 5 | Operation code (0..16) |
| in_oe | input | 1 | Request overflow recording |
| in_rc | input | 1 | Request sign/zero code |
| in_ra_zero | input | 1 | First register field was zero |
| in_ra | input | 64 | First register operand |
| in_rb | input | 64 | Second register operand |
| in_imm | input | 16 | Signed immediate |
| in_nia | input | 64 | Next-instruction address |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | Sum |
| out_carry | output | 1 | Carry-out of the sum |
| out_ovf | output | 1 | Signed overflow of the sum |
| out_cr | output | 3 | {negative, positive, zero} or 000 |
| out_ov_wr | output | 1 | Overflow bit was recorded |
| ca_q | output | 1 | Stored carry bit |
| ov_q | output | 1 | Stored overflow bit |

## Verification
Every result of an operation issued in cycle n, including the updated ca_q and ov_q, is due in cycle n+1, because one register rank sits between the inputs and all outputs. The bench drives each operation at a falling edge and lets one rising edge pass. It compares every output at the next falling edge against a model that advances its own carry and overflow bits at that same point. Because of this, an operation issued directly after another sees the status the earlier one wrote. Idle cycles are compared the same way, to confirm that out_valid drops and the status bits hold.

// File: rtl/fxu_pkg.sv
package fxu_pkg;

    typedef enum logic [4:0] {
        OP_ADD     = 5'd0,
        OP_SUBF    = 5'd1,
        OP_ADDI    = 5'd2,
        OP_ADDIS   = 5'd3,
        OP_ADDPCIS = 5'd4,
        OP_ADDIC   = 5'd5,
        OP_SUBFIC  = 5'd6,
        OP_ADDC    = 5'd7,
        OP_SUBFC   = 5'd8,
        OP_ADDE    = 5'd9,
        OP_SUBFE   = 5'd10,
        OP_ADDME   = 5'd11,
        OP_SUBFME  = 5'd12,
        OP_ADDZE   = 5'd13,
        OP_SUBFZE  = 5'd14,
        OP_ADDEX   = 5'd15,
        OP_NEG     = 5'd16
    } fxu_op_e;

    // operations whose carry-out lands in the stored carry bit
    function automatic logic op_writes_ca(fxu_op_e op);
        case (op)
            OP_ADDIC, OP_SUBFIC, OP_ADDC, OP_SUBFC, OP_ADDE, OP_SUBFE,
            OP_ADDME, OP_SUBFME, OP_ADDZE, OP_SUBFZE: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    // operations for which the OE bit records signed overflow
    function automatic logic op_honours_oe(fxu_op_e op);
        case (op)
            OP_ADD, OP_SUBF, OP_ADDC, OP_SUBFC, OP_ADDE, OP_SUBFE,
            OP_ADDME, OP_SUBFME, OP_ADDZE, OP_SUBFZE, OP_NEG: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/fxu_operand_sel.sv
module fxu_operand_sel
    import fxu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16
) (
    input  fxu_op_e            op,
    input  logic               ra_zero,
    input  logic [XLEN-1:0]    ra,
    input  logic [XLEN-1:0]    rb,
    input  logic [IMM_W-1:0]   imm,
    input  logic [XLEN-1:0]    nia,
    input  logic               ca,
    input  logic               ov,
    output logic [XLEN-1:0]    opa,
    output logic [XLEN-1:0]    opb,
    output logic               cin
);
    localparam int LO_EXT = XLEN - IMM_W;
    localparam int HI_EXT = XLEN - 2 * IMM_W;

    logic [XLEN-1:0] imm_lo;
    logic [XLEN-1:0] imm_hi;
    logic [XLEN-1:0] ra_or_zero;
    logic [XLEN-1:0] ra_inv;

    assign imm_lo     = {{LO_EXT{imm[IMM_W-1]}}, imm};
    assign imm_hi     = {{HI_EXT{imm[IMM_W-1]}}, imm, {IMM_W{1'b0}}};
    assign ra_or_zero = ra_zero ? '0 : ra;
    assign ra_inv     = ~ra;

    always_comb begin
        opa = ra;
        opb = rb;
        cin = 1'b0;
        case (op)
            OP_ADD:     begin opa = ra;         opb = rb;      cin = 1'b0; end
            OP_SUBF:    begin opa = ra_inv;     opb = rb;      cin = 1'b1; end
            OP_ADDI:    begin opa = ra_or_zero; opb = imm_lo;  cin = 1'b0; end
            OP_ADDIS:   begin opa = ra_or_zero; opb = imm_hi;  cin = 1'b0; end
            OP_ADDPCIS: begin opa = nia;        opb = imm_hi;  cin = 1'b0; end
            OP_ADDIC:   begin opa = ra;         opb = imm_lo;  cin = 1'b0; end
            OP_SUBFIC:  begin opa = ra_inv;     opb = imm_lo;  cin = 1'b1; end
            OP_ADDC:    begin opa = ra;         opb = rb;      cin = 1'b0; end
            OP_SUBFC:   begin opa = ra_inv;     opb = rb;      cin = 1'b1; end
            OP_ADDE:    begin opa = ra;         opb = rb;      cin = ca;   end
            OP_SUBFE:   begin opa = ra_inv;     opb = rb;      cin = ca;   end
            OP_ADDME:   begin opa = ra;         opb = '1;      cin = ca;   end
            OP_SUBFME:  begin opa = ra_inv;     opb = '1;      cin = ca;   end
            OP_ADDZE:   begin opa = ra;         opb = '0;      cin = ca;   end
            OP_SUBFZE:  begin opa = ra_inv;     opb = '0;      cin = ca;   end
            OP_ADDEX:   begin opa = ra;         opb = rb;      cin = ov;   end
            OP_NEG:     begin opa = ra_inv;     opb = '0;      cin = 1'b1; end
            default:    begin opa = ra;         opb = rb;      cin = 1'b0; end
        endcase
    end

endmodule

// File: rtl/fxu_csel_adder.sv
module fxu_csel_adder #(
    parameter int XLEN  = 64,
    parameter int BLK_W = 16
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  logic            cin,
    output logic [XLEN-1:0] sum,
    output logic            cout,
    output logic            ovf,
    output logic [2:0]      sgn_code
);
    localparam int NBLK = XLEN / BLK_W;

    logic [NBLK:0] carry;
    assign carry[0] = cin;

    for (genvar gi = 0; gi < NBLK; gi++) begin : g_blk
        logic [BLK_W:0] s_c0;
        logic [BLK_W:0] s_c1;
        assign s_c0 = {1'b0, opa[gi*BLK_W +: BLK_W]} + {1'b0, opb[gi*BLK_W +: BLK_W]};
        assign s_c1 = s_c0 + (BLK_W+1)'(1);
        assign sum[gi*BLK_W +: BLK_W] = carry[gi] ? s_c1[BLK_W-1:0] : s_c0[BLK_W-1:0];
        assign carry[gi+1]            = carry[gi] ? s_c1[BLK_W]     : s_c0[BLK_W];
    end

    logic is_zero;
    logic is_neg;

    assign cout     = carry[NBLK];
    assign ovf      = (opa[XLEN-1] == opb[XLEN-1]) && (sum[XLEN-1] != opa[XLEN-1]);
    assign is_zero  = (sum == '0);
    assign is_neg   = sum[XLEN-1];
    assign sgn_code = {is_neg, !is_neg && !is_zero, is_zero};

endmodule

// File: rtl/fxu_addsub.sv
module fxu_addsub
    import fxu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16,
    parameter int BLK_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [4:0]         in_op,
    input  logic               in_oe,
    input  logic               in_rc,
    input  logic               in_ra_zero,
    input  logic [XLEN-1:0]    in_ra,
    input  logic [XLEN-1:0]    in_rb,
    input  logic [IMM_W-1:0]   in_imm,
    input  logic [XLEN-1:0]    in_nia,
    output logic               out_valid,
    output logic [XLEN-1:0]    out_result,
    output logic               out_carry,
    output logic               out_ovf,
    output logic [2:0]         out_cr,
    output logic               out_ov_wr,
    output logic               ca_q,
    output logic               ov_q
);
    typedef struct packed {
        logic            vld;
        logic [XLEN-1:0] res;
        logic            carry;
        logic            ovf;
        logic [2:0]      cr;
        logic            ov_wr;
        logic            ca;
        logic            ov;
    } fxu_state_t;

    fxu_state_t st_d, st_q;
    fxu_op_e    op;

    logic [XLEN-1:0] opa, opb, sum;
    logic            cin, cout, ovf;
    logic [2:0]      sgn_code;

    assign op = fxu_op_e'(in_op);

    fxu_operand_sel #(.XLEN(XLEN), .IMM_W(IMM_W)) u_sel (
        .op      (op),
        .ra_zero (in_ra_zero),
        .ra      (in_ra),
        .rb      (in_rb),
        .imm     (in_imm),
        .nia     (in_nia),
        .ca      (st_q.ca),
        .ov      (st_q.ov),
        .opa     (opa),
        .opb     (opb),
        .cin     (cin)
    );

    fxu_csel_adder #(.XLEN(XLEN), .BLK_W(BLK_W)) u_add (
        .opa      (opa),
        .opb      (opb),
        .cin      (cin),
        .sum      (sum),
        .cout     (cout),
        .ovf      (ovf),
        .sgn_code (sgn_code)
    );

    always_comb begin
        st_d       = st_q;
        st_d.vld   = in_valid;
        st_d.ov_wr = 1'b0;
        if (in_valid) begin
            st_d.res   = sum;
            st_d.carry = cout;
            st_d.ovf   = ovf;
            st_d.cr    = in_rc ? sgn_code : 3'b000;
            st_d.ov_wr = in_oe && op_honours_oe(op);
            if (op_writes_ca(op)) begin
                st_d.ca = cout;
            end
            if (op == OP_ADDEX) begin
                st_d.ov = cout;
            end else if (in_oe && op_honours_oe(op)) begin
                st_d.ov = ovf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign out_result = st_q.res;
    assign out_carry  = st_q.carry;
    assign out_ovf    = st_q.ovf;
    assign out_cr     = st_q.cr;
    assign out_ov_wr  = st_q.ov_wr;
    assign ca_q       = st_q.ca;
    assign ov_q       = st_q.ov;

endmodule

// File: rtl/fxu_addsub_chk.sv
module fxu_addsub_chk
    import fxu_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int IMM_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [4:0]       in_op,
    input logic             in_oe,
    input logic             in_rc,
    input logic             in_ra_zero,
    input logic [XLEN-1:0]  in_ra,
    input logic [XLEN-1:0]  in_rb,
    input logic [IMM_W-1:0] in_imm,
    input logic [XLEN-1:0]  in_nia,
    input logic             out_valid,
    input logic [XLEN-1:0]  out_result,
    input logic             out_carry,
    input logic             out_ovf,
    input logic [2:0]       out_cr,
    input logic             out_ov_wr,
    input logic             ca_q,
    input logic             ov_q
);
    logic carry_class;
    assign carry_class = (in_op >= 5'd5) && (in_op <= 5'd14);

    AST_VALID_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R2
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid); // R2
    AST_SUBF_DIFF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_SUBF) |=> out_result == ($past(in_rb) - $past(in_ra))); // R3
    AST_NEG_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_NEG) |=> out_result == (XLEN'(0) - $past(in_ra))); // R3
    AST_CA_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && carry_class) |=> ca_q == out_carry); // R6
    AST_ALT_CA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ADDEX) |=> $stable(ca_q)); // R8
    AST_ALT_OV_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == OP_ADDEX) |=> (ov_q == out_carry) && !out_ov_wr); // R8
    AST_OVWR_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_ov_wr |-> out_valid); // R9
    AST_OV_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        out_ov_wr |-> ov_q == out_ovf); // R9
    AST_CR_ONE_HOT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_rc) |=> $countones(out_cr) == 1); // R10
    AST_CR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_rc) |=> out_cr == 3'b000); // R10
    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(ca_q) && $stable(ov_q)); // R12

endmodule

bind fxu_addsub fxu_addsub_chk #(.XLEN(XLEN), .IMM_W(IMM_W)) u_chk (.*);

// File: tb/fxu_addsub_test.sv
module fxu_addsub_test;
    localparam int CLK_PERIOD = 10;
    localparam int XL = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [4:0]    in_op = '0;
    logic          in_oe = 1'b0;
    logic          in_rc = 1'b0;
    logic          in_ra_zero = 1'b0;
    logic [XL-1:0] in_ra = '0;
    logic [XL-1:0] in_rb = '0;
    logic [15:0]   in_imm = '0;
    logic [XL-1:0] in_nia = '0;
    logic          out_valid, out_carry, out_ovf, out_ov_wr, ca_q, ov_q;
    logic [XL-1:0] out_result;
    logic [2:0]    out_cr;

    int n_chk = 0;
    int n_bad = 0;
    bit m_ca = 1'b0;
    bit m_ov = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fxu_addsub uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_oe(in_oe), .in_rc(in_rc), .in_ra_zero(in_ra_zero),
        .in_ra(in_ra), .in_rb(in_rb), .in_imm(in_imm), .in_nia(in_nia),
        .out_valid(out_valid), .out_result(out_result), .out_carry(out_carry),
        .out_ovf(out_ovf), .out_cr(out_cr), .out_ov_wr(out_ov_wr),
        .ca_q(ca_q), .ov_q(ov_q)
    );

    task automatic chk(input string req, input logic [XL-1:0] act, input logic [XL-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // behavioural reference: terms of the addition per operation
    task automatic issue(input int op, input bit oe, input bit rc, input bit raz,
                         input logic [XL-1:0] ra, input logic [XL-1:0] rb,
                         input logic [15:0] imm, input logic [XL-1:0] nia, input string req);
        logic [XL-1:0] a, b, e_res, se, sh;
        logic [64:0]   u;
        logic [65:0]   s;
        bit c, e_cy, e_ov, wr_ca, oe_ok, e_wr;
        logic [2:0] e_cr;
        se = XL'($signed(imm));
        sh = XL'($signed({imm, 16'h0000}));
        a = ra; b = rb; c = 1'b0; wr_ca = 1'b0; oe_ok = 1'b0;
        case (op)
            0:  begin oe_ok = 1; end
            1:  begin a = ~ra; c = 1; oe_ok = 1; end
            2:  begin a = raz ? 64'd0 : ra; b = se; end
            3:  begin a = raz ? 64'd0 : ra; b = sh; end
            4:  begin a = nia; b = sh; end
            5:  begin b = se; wr_ca = 1; end
            6:  begin a = ~ra; b = se; c = 1; wr_ca = 1; end
            7:  begin wr_ca = 1; oe_ok = 1; end
            8:  begin a = ~ra; c = 1; wr_ca = 1; oe_ok = 1; end
            9:  begin c = m_ca; wr_ca = 1; oe_ok = 1; end
            10: begin a = ~ra; c = m_ca; wr_ca = 1; oe_ok = 1; end
            11: begin b = '1; c = m_ca; wr_ca = 1; oe_ok = 1; end
            12: begin a = ~ra; b = '1; c = m_ca; wr_ca = 1; oe_ok = 1; end
            13: begin b = '0; c = m_ca; wr_ca = 1; oe_ok = 1; end
            14: begin a = ~ra; b = '0; c = m_ca; wr_ca = 1; oe_ok = 1; end
            15: begin c = m_ov; end
            default: begin a = ~ra; b = '0; c = 1; oe_ok = 1; end
        endcase
        u = {1'b0, a} + {1'b0, b} + 65'(c);
        s = {{2{a[63]}}, a} + {{2{b[63]}}, b} + 66'(c);
        e_res = u[63:0];
        e_cy  = u[64];
        e_ov  = s[64] ^ s[63];
        e_wr  = oe && oe_ok;
        e_cr  = !rc ? 3'b000 : ($signed(e_res) < 0) ? 3'b100 : (e_res == 0) ? 3'b001 : 3'b010;
        if (wr_ca) m_ca = e_cy;
        if (op == 15) m_ov = e_cy;
        else if (e_wr) m_ov = e_ov;

        in_valid = 1'b1; in_op = 5'(op); in_oe = oe; in_rc = rc; in_ra_zero = raz;
        in_ra = ra; in_rb = rb; in_imm = imm; in_nia = nia;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        chk({req, " R2 valid"}, 64'(out_valid), 64'd1);
        chk({req, " result"}, out_result, e_res);
        chk({req, " R6 R11 carry"}, 64'(out_carry), 64'(e_cy));
        chk({req, " R9 ovf"}, 64'(out_ovf), 64'(e_ov));
        chk({req, " R10 cr"}, 64'(out_cr), 64'(e_cr));
        chk({req, " R9 ov_wr"}, 64'(out_ov_wr), 64'(e_wr));
        chk({req, " R6 R7 ca_q"}, 64'(ca_q), 64'(m_ca));
        chk({req, " R8 R9 ov_q"}, 64'(ov_q), 64'(m_ov));
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            in_valid = 1'b0;
            in_ra = {$urandom, $urandom};
            in_op = 5'd9;
            @(posedge clk);
            @(negedge clk);
            chk("R2 idle valid", 64'(out_valid), 64'd0);
            chk("R12 idle ca_q", 64'(ca_q), 64'(m_ca));
            chk("R12 idle ov_q", 64'(ov_q), 64'(m_ov));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", 64'(out_valid), 64'd0);
        chk("R1 reset result", out_result, 64'd0);
        chk("R1 reset cr", 64'(out_cr), 64'd0);
        chk("R1 reset status", 64'({out_carry, out_ovf, out_ov_wr, ca_q, ov_q}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 64'({out_valid, ca_q, ov_q}), 64'd0);

        // R3 plain add/subtract and negate
        issue(0, 0, 1, 0, 64'd5, 64'd7, 16'h0, 64'h0, "R3 add");
        issue(1, 0, 1, 0, 64'd9, 64'd4, 16'h0, 64'h0, "R3 subf neg result");
        issue(1, 0, 1, 0, 64'd4, 64'd4, 16'h0, 64'h0, "R3 subf zero");
        issue(16, 1, 1, 0, 64'd0, 64'd0, 16'h0, 64'h0, "R3 neg zero");
        issue(16, 1, 1, 0, 64'h8000_0000_0000_0000, 64'd0, 16'h0, 64'h0, "R3 R9 neg min");
        // R4 immediates with zero-field selection
        issue(2, 0, 0, 1, 64'h1234, 64'd0, 16'hFFFE, 64'h0, "R4 addi zero field");
        issue(2, 1, 0, 0, 64'h1234, 64'd0, 16'hFFFE, 64'h0, "R4 R9 addi oe ignored");
        issue(3, 0, 0, 0, 64'd1, 64'd0, 16'h8001, 64'h0, "R4 addis negative");
        issue(3, 0, 0, 1, 64'd1, 64'd0, 16'h7FFF, 64'h0, "R4 addis zero field");
        issue(0, 0, 0, 1, 64'd3, 64'd4, 16'h0, 64'h0, "R4 add ignores zero field");
        // R5
        issue(4, 0, 1, 1, 64'hDEAD, 64'd0, 16'hFFFF, 64'h1000_0000, "R5 pc rel");
        // R6 carrying forms, carry across block boundaries
        issue(5, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 16'h0001, 64'h0, "R6 R11 addic ripple");
        issue(6, 0, 1, 0, 64'd10, 64'd0, 16'h0003, 64'h0, "R6 subfic");
        issue(7, 1, 1, 0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h0, "R6 R9 addc ovf");
        issue(8, 1, 0, 0, 64'd1, 64'd1, 16'h0, 64'h0, "R6 R9 subfc clear");
        issue(0, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h0, "R6 add keeps ca");
        issue(11, 0, 0, 0, 64'h0000_0000_FFFF_0000, 64'd0, 16'h0, 64'h0, "R7 addme ca1");
        // R7 extended chains
        issue(7, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd2, 16'h0, 64'h0, "R7 setup ca");
        issue(9, 0, 0, 0, 64'd1, 64'd1, 16'h0, 64'h0, "R7 adde ca1");
        issue(9, 0, 0, 0, 64'd1, 64'd1, 16'h0, 64'h0, "R7 adde ca0");
        issue(10, 0, 0, 0, 64'd3, 64'd3, 16'h0, 64'h0, "R7 subfe");
        issue(12, 0, 0, 0, 64'd0, 64'd0, 16'h0, 64'h0, "R7 subfme");
        issue(13, 0, 1, 0, 64'd0, 64'd0, 16'h0, 64'h0, "R7 addze");
        issue(14, 1, 1, 0, 64'd5, 64'd0, 16'h0, 64'h0, "R7 subfze");
        // R8 alternate carry through overflow bit
        issue(15, 1, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'd1, 16'h0, 64'h0, "R8 addex set");
        issue(15, 0, 0, 0, 64'd1, 64'd1, 16'h0, 64'h0, "R8 addex uses ov");
        issue(15, 1, 0, 0, 64'd1, 64'd1, 16'h0, 64'h0, "R8 addex clears");
        idle(4);
        for (int i = 0; i < 400; i++) begin
            logic [XL-1:0] ra, rb;
            ra = {$urandom, $urandom};
            rb = {$urandom, $urandom};
            if (i % 7 == 0) ra = 64'h8000_0000_0000_0000;
            if (i % 11 == 0) rb = '1;
            issue(int'($urandom_range(0, 16)), 1'($urandom), 1'($urandom), 1'($urandom),
                  ra, rb, 16'($urandom), {$urandom, $urandom}, "R3 R9 random");
            if (i % 50 == 0) idle(1);
        end
        summary();
        $finish;
    end

endmodule